// File: doc/BRIEF.md
# UART Receive Queue with Status and Error Reporting

This block sits between a serial-line deserializer and a register interface. Each received character arrives as a one-cycle beat on a valid/ready stream, with flags for parity error, framing error and break. Characters are kept in a first-in-first-out queue while queue mode is on. When queue mode is off, a single holding register keeps the most recent character. Software drains characters through a read-side register port and sees an occupancy word, a sticky error word that clears when read, and a line word. A one-cycle error pulse goes to the interrupt logic outside the block.

The stream source is a serial line and cannot wait. It presents each beat for exactly one cycle. A beat is taken when `in_valid` and `in_ready` are both high. A beat offered while `in_ready` is low is discarded and recorded as an overrun. In queue mode `in_ready` is high exactly when a free entry exists. It is taken from registered state only, so a pop in the same cycle does not raise it. In bypass mode `in_ready` is always high.

Top module: `uart_rxq`

## Requirements
- R1: After reset, queue mode is off, the queue is empty, the error word is 0, the line word is 0, `in_ready` is 1 and `err_evt` is 0.
- R2: The occupancy word (`rd_sel`=1) holds the entry count in bits [7:0] and a full flag in bit 8. When every entry is used, bit 8 is 1 and bits [7:0] read 0.
- R3: In queue mode a data read (`rd_sel`=0, `rd_en`=1) returns the oldest stored byte in bits [7:0] and removes it. Bytes come out in arrival order.
- R4: In queue mode `in_ready` is 1 exactly when the queue has a free entry. A beat offered while `in_ready` is 0 is discarded, sets overrun, and pulses `err_evt`.
- R5: Line word (`rd_sel`=3): bit 0 is data-ready and bit 1 is queue mode. In queue mode, data-ready is 1 exactly when the queue holds a byte, so it clears on the pop that empties the queue.
- R6: A data read in queue mode while the queue is empty returns 0, leaves the queue unchanged and drives `err_evt` high in the following cycle.
- R7: Error word (`rd_sel`=2): overrun is bit 0, parity bit 1, frame bit 2, break bit 3. The bits are sticky. A read with `rd_en` returns the current value and clears it. An error arriving in the same cycle as the read survives the clear.
- R8: A beat with `in_brk` set stores 0x00 whatever `in_data` holds, and sets error bit 3.
- R9: In bypass mode a beat loads the holding register and sets data-ready. A data read returns the held byte and clears data-ready. A beat arriving while data-ready is set and no read is taking the old byte overwrites it, sets overrun and pulses `err_evt`.
- R10: A control write sets queue mode from `wr_data[0]`. `wr_data[1]`=1 empties the queue, is not stored, and takes priority over a same-cycle push or pop.
- R11: A push and a pop in the same cycle leave the entry count unchanged, and the count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received character beat present |
| in_ready | output | 1 | Beat will be taken this cycle |
| in_data | input | 8 | Received character |
| in_brk | input | 1 | Beat is a break condition |
| in_perr | input | 1 | Beat had a parity error |
| in_ferr | input | 1 | Beat had a framing error |
| rd_en | input | 1 | Register read strobe (applies side effects) |
| rd_sel | input | 2 | 0 data, 1 occupancy, 2 error, 3 line |
| rd_data | output | 32 | Selected register value, combinational |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 2 | Bit 0 queue mode, bit 1 flush |
| err_evt | output | 1 | One-cycle error pulse |

## Verification
The bench goes after the full boundary. A design that counted to DEPTH in eight bits would show a nonzero count beside the full flag, and one that took a beat while full would overwrite the oldest byte. It reads the empty queue to catch a design that returns stale storage or moves a pointer past the write pointer. It issues an error-word read in the same cycle as a new line error, which exposes a clear that wins over a set. Flush is issued together with a push, and bypass overwrite is issued both with and without a same-cycle read; mixing up their priorities changes either the data that comes out or the overrun bit.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_OCC   = 2'd1,
    SEL_ERR   = 2'd2,
    SEL_LINE  = 2'd3
  } rxq_sel_e;

  localparam int ERR_W   = 4;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;

  localparam int CTL_MODE  = 0;
  localparam int CTL_FLUSH = 1;

  localparam int OCC_FULL_BIT = 8;
endpackage

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  store [DEPTH];
  logic [CW-1:0] wptr, rptr;

  assign count = wptr - rptr;
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = store[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + CW'(1);
      if (pop && !empty) rptr <= rptr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) store[wptr[AW-1:0]] <= push_data;
  end
endmodule

// File: rtl/uart_rxq_errstat.sv
module uart_rxq_errstat
  import uart_rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set,
  input  logic             clr,
  output logic [ERR_W-1:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (clr ? '0 : stat) | set;
  end
endmodule

// File: rtl/uart_rxq_hold.sv
module uart_rxq_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  output logic [W-1:0] data,
  output logic         vld,
  output logic         clobber
);
  assign clobber = load && vld && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      vld  <= 1'b0;
    end else if (load) begin
      data <= load_data;
      vld  <= 1'b1;
    end else if (take) begin
      vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int DW   = 32,
  localparam int BW   = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_data,
  input  logic          in_brk,
  input  logic          in_perr,
  input  logic          in_ferr,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [1:0]    wr_data,
  output logic          err_evt
);
  logic             fifo_en;
  logic             do_flush;
  logic [BW-1:0]    beat_byte;
  logic             rd_pop;
  logic             q_push, q_pop, q_full, q_empty;
  logic [BW-1:0]    q_head;
  logic [CW-1:0]    q_count;
  logic             h_load, h_take, h_vld, h_clobber;
  logic [BW-1:0]    h_data;
  logic             drop, empty_rd;
  logic [ERR_W-1:0] err_set, err_stat;
  logic             rdy;
  rxq_sel_e         sel;

  assign sel       = rxq_sel_e'(rd_sel);
  assign do_flush  = wr_en && wr_data[CTL_FLUSH];
  assign beat_byte = in_brk ? '0 : in_data;
  assign rd_pop    = rd_en && (sel == SEL_DATA);

  assign in_ready  = fifo_en ? !q_full : 1'b1;
  assign drop      = in_valid && !in_ready;
  assign q_push    = fifo_en && in_valid && in_ready;
  assign q_pop     = fifo_en && rd_pop;
  assign empty_rd  = fifo_en && rd_pop && q_empty;

  assign h_load    = !fifo_en && in_valid;
  assign h_take    = !fifo_en && rd_pop;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = drop || h_clobber;
    err_set[ERR_PAR] = in_valid && in_perr;
    err_set[ERR_FRM] = in_valid && in_ferr;
    err_set[ERR_BRK] = in_valid && in_brk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      err_evt <= 1'b0;
    end else begin
      if (wr_en) fifo_en <= wr_data[CTL_MODE];
      err_evt <= drop || h_clobber || empty_rd;
    end
  end

  uart_rxq_mem #(.DEPTH(DEPTH), .W(BW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (do_flush),
    .push      (q_push),
    .push_data (beat_byte),
    .pop       (q_pop),
    .head      (q_head),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  uart_rxq_hold #(.W(BW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (h_load),
    .load_data (beat_byte),
    .take      (h_take),
    .data      (h_data),
    .vld       (h_vld),
    .clobber   (h_clobber)
  );

  uart_rxq_errstat u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (rd_en && (sel == SEL_ERR)),
    .stat  (err_stat)
  );

  assign rdy = fifo_en ? !q_empty : h_vld;

  always_comb begin
    rd_data = '0;
    unique case (sel)
      SEL_DATA: rd_data[BW-1:0] = fifo_en ? (q_empty ? '0 : q_head) : h_data;
      SEL_OCC: begin
        rd_data[OCC_FULL_BIT] = q_full;
        rd_data[7:0]          = q_full ? 8'h00 : 8'(q_count);
      end
      SEL_ERR:  rd_data[ERR_W-1:0] = err_stat;
      SEL_LINE: rd_data[1:0] = {fifo_en, rdy};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_brk,
  input logic          rd_en,
  input logic [1:0]    rd_sel,
  input logic [31:0]   rd_data,
  input logic          wr_en,
  input logic [1:0]    wr_data,
  input logic          err_evt,
  input logic          fifo_en,
  input logic [CW-1:0] count,
  input logic          full,
  input logic [3:0]    estat
);
  a_r2_full_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1 && full) |-> (rd_data[8] && rd_data[7:0] == 8'h00));

  a_r4_ready_tracks_space: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> (in_ready == !full));

  a_r4_bypass_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> in_ready);

  a_r5_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd3 && fifo_en) |-> (rd_data[0] == (count != '0)));

  a_r6_empty_read_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd0 && fifo_en && count == '0) |=> err_evt);

  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd2 && !in_valid) |=> (estat == 4'h0));

  a_r8_break_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_brk) |=> estat[3]);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1]) |=> (count == '0));

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_brk   (in_brk),
  .rd_en    (rd_en),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .err_evt  (err_evt),
  .fifo_en  (fifo_en),
  .count    (q_count),
  .full     (q_full),
  .estat    (err_stat)
);

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_brk = 0, in_perr = 0, in_ferr = 0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        rd_en = 0, wr_en = 0;
  logic [1:0]  rd_sel = '0, wr_data = '0;
  logic [31:0] rd_data;
  logic        err_evt;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  int        m_q[$];
  bit        m_en, m_hvld, m_evt;
  bit [7:0]  m_hold;
  bit [3:0]  m_est;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rxq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_brk(in_brk), .in_perr(in_perr), .in_ferr(in_ferr),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_en(wr_en), .wr_data(wr_data), .err_evt(err_evt)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    int cnt = m_q.size();
    case (rd_sel)
      2'd0: v[7:0] = m_en ? (cnt == 0 ? 8'h00 : 8'(m_q[0])) : m_hold;
      2'd1: begin
        v[8]   = (cnt == DEPTH);
        v[7:0] = (cnt == DEPTH) ? 8'h00 : 8'(cnt);
      end
      2'd2: v[3:0] = m_est;
      default: v[1:0] = {m_en, m_en ? (cnt != 0) : m_hvld};
    endcase
    return v;
  endfunction

  task automatic model_update();
    bit full = (m_q.size() == DEPTH);
    bit rdyin = m_en ? !full : 1'b1;
    bit flush = wr_en && wr_data[1];
    bit pop = rd_en && rd_sel == 2'd0;
    bit [3:0] set = '0;
    bit evt = 0;
    int b = in_brk ? 0 : int'(in_data);
    if (in_valid) begin
      set[1] = in_perr; set[2] = in_ferr; set[3] = in_brk;
    end
    if (m_en) begin
      if (in_valid && !rdyin) begin set[0] = 1; evt = 1; end
      if (pop && m_q.size() == 0) evt = 1;
      if (!flush) begin
        if (pop && m_q.size() > 0) void'(m_q.pop_front());
        if (in_valid && rdyin) m_q.push_back(b);
      end
    end else begin
      if (in_valid) begin
        if (m_hvld && !pop) begin set[0] = 1; evt = 1; end
        m_hold = 8'(b); m_hvld = 1;
      end else if (pop) m_hvld = 0;
    end
    if (flush) m_q.delete();
    if (rd_en && rd_sel == 2'd2) m_est = set; else m_est |= set;
    if (wr_en) m_en = wr_data[0];
    m_evt = evt;
  endtask

  task automatic tick(string tag);
    #1;
    check(tag, "in_ready", 32'(in_ready), 32'(m_en ? (m_q.size() < DEPTH) : 1'b1));
    check(tag, "rd_data", rd_data, exp_rd());
    check(tag, "err_evt", 32'(err_evt), 32'(m_evt));
    @(posedge clk);
    model_update();
    @(negedge clk);
    in_valid = 0; in_brk = 0; in_perr = 0; in_ferr = 0;
    rd_en = 0; wr_en = 0;
  endtask

  task automatic push(input logic [7:0] d, input string tag);
    in_valid = 1; in_data = d; tick(tag);
  endtask

  task automatic rd(input logic [1:0] s, input string tag);
    rd_sel = s; rd_en = 1; tick(tag);
  endtask

  task automatic look(input logic [1:0] s, input string tag);
    rd_sel = s; tick(tag);
  endtask

  task automatic ctl(input logic [1:0] v, input string tag);
    wr_en = 1; wr_data = v; tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_hvld = 0; m_evt = 0; m_hold = '0; m_est = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state on every register view
    for (int s = 0; s < 4; s++) look(2'(s), "R1");

    // R9: bypass holding register
    push(8'h41, "R9"); look(2'd3, "R9"); rd(2'd0, "R9"); look(2'd3, "R9");
    push(8'h42, "R9"); push(8'h43, "R9"); look(2'd0, "R9"); rd(2'd2, "R9");
    push(8'h44, "R9"); in_valid = 1; in_data = 8'h45; rd_sel = 2'd0; rd_en = 1; tick("R9");
    look(2'd2, "R9"); rd(2'd0, "R9");

    // R10: enable queue mode
    ctl(2'b01, "R10"); look(2'd3, "R10");

    // R3: order
    for (int i = 1; i <= 5; i++) push(8'(8'h10 + i), "R3");
    look(2'd1, "R3");
    for (int i = 0; i < 5; i++) begin rd(2'd0, "R3"); look(2'd3, "R5"); end

    // R6: read while empty
    rd(2'd0, "R6"); rd(2'd0, "R6"); look(2'd1, "R6");

    // R2 / R4: fill to full, then overflow
    for (int i = 0; i < DEPTH; i++) push(8'(8'h80 + i), "R2");
    look(2'd1, "R2"); push(8'hEE, "R4"); look(2'd0, "R4"); rd(2'd2, "R4");

    // R11: simultaneous push and pop
    rd(2'd0, "R11");
    in_valid = 1; in_data = 8'h77; rd_sel = 2'd0; rd_en = 1; tick("R11");
    look(2'd1, "R11");

    // R10: flush with same-cycle push
    in_valid = 1; in_data = 8'h99; wr_en = 1; wr_data = 2'b11; tick("R10");
    look(2'd1, "R10"); look(2'd3, "R10"); rd(2'd0, "R10");

    // R8: break stores null
    in_valid = 1; in_data = 8'hFF; in_brk = 1; tick("R8");
    look(2'd2, "R8"); rd(2'd0, "R8");

    // R7: clear-on-read with same-cycle error
    in_valid = 1; in_data = 8'h31; in_perr = 1; tick("R7");
    look(2'd2, "R7");
    in_valid = 1; in_data = 8'h32; in_ferr = 1; rd_sel = 2'd2; rd_en = 1; tick("R7");
    rd(2'd2, "R7"); look(2'd2, "R7");

    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      in_valid = $urandom_range(0, 1) == 1;
      in_data  = 8'($urandom);
      in_brk   = $urandom_range(0, 15) == 0;
      in_perr  = $urandom_range(0, 15) == 0;
      in_ferr  = $urandom_range(0, 15) == 0;
      rd_sel   = 2'($urandom);
      rd_en    = $urandom_range(0, 2) == 0;
      wr_en    = $urandom_range(0, 63) == 0;
      wr_data  = {$urandom_range(0, 3) == 0, $urandom_range(0, 4) != 0};
      tick("R3");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule